// File: doc/BRIEF.md
# Voltage/Frequency Operating Point Sequencer

This block is the hardware half of runtime voltage and frequency scaling for a processor cluster. Software decides which operating point the cluster should run at and writes an index. The sequencer then carries out the move between two entries of a fixed table of validated voltage/frequency pairs. It drives a target code to an external supply regulator, waits for the regulator to report that the rail has settled, and drives a frequency-select code to the clock generator. While the rail is moving, it holds the cluster clock gated.

The ordering of the two changes depends on the direction of the move. When performance rises, the rail must be raised and settled before the clock speeds up. When power drops, the clock slows first and the rail follows. A settle wait that overruns a programmable cycle budget aborts the move: the regulator target goes back to its old value and the clock stays at the old point. Requests that are redundant, out of range or too early are handled without disturbing the rail.

Top module: `dvfs_seq_top`

## Requirements
- R1: After reset the current index is 0, `vreg_code` and `freq_code` hold entry 0 (60 and 300), `clk_en` is 1, and `busy`, `done` and all error flags are 0.
- R2: Entry i of an N-entry table has voltage code 60 + floor(i*45/(N-1)) in 10 mV units and frequency code 300 + floor(i*2700/(N-1)) in MHz. With N = 8 the lowest entry is (60, 300) and the highest is (105, 3000).
- R3: For a request above the current index, `vreg_code` changes to the target first. `freq_code` changes to the target only after `vreg_settled` has been sampled high, and strictly later than the voltage change.
- R4: For a request below the current index, `freq_code` changes to the target first. `vreg_code` changes strictly later.
- R5: `clk_en` falls exactly one cycle before `vreg_code` changes. It stays low while the rail moves and rises again only in the cycle after the final frequency code has been applied. Whenever the block is idle, `clk_en` is 1.
- R6: A move raises `busy` from the cycle after acceptance until it completes. At completion the block gives a one-cycle `done` pulse, `busy` drops and `cur_index` takes the target index.
- R7: A request equal to `cur_index` gives a `done` pulse in the next cycle. It changes neither code, leaves `clk_en` high and never raises `busy`.
- R8: A request with index >= N pulses `err_range` for one cycle. It changes no code, does not pulse `done` and leaves `cur_index` unchanged.
- R9: A request while `busy` is 1 is ignored and pulses `err_overrun` in the next cycle. The move in flight ends at its own target.
- R10: If `vreg_settled` is not sampled high in `timeout_limit` consecutive wait cycles (0 counts as 1), `vreg_code` returns to the previous point's code. This happens `timeout_limit` cycles after the target code was applied.
- R11: After a timeout, the block waits for settle (or another timeout) and leaves `freq_code` at the previous point's frequency. It then finishes with `done` and `err_timeout` pulsed together, and `cur_index` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle strobe of a new operating point request |
| req_index | input | IDX_W | Requested table index |
| timeout_limit | input | TMO_W | Settle wait budget in cycles |
| vreg_settled | input | 1 | Regulator reports the rail is at its target |
| vreg_code | output | VCODE_W | Voltage target to the regulator, 10 mV units |
| freq_code | output | FCODE_W | Frequency select to the clock generator, MHz |
| clk_en | output | 1 | Cluster clock gate enable |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | One-cycle pulse: request index out of range |
| err_overrun | output | 1 | One-cycle pulse: request arrived while busy |
| err_timeout | output | 1 | One-cycle pulse with done: settle timed out |
| cur_index | output | IDX_W | Index of the point now in force |

## Verification
The bound checker watches the safety rules on every cycle:
- the regulator code never moves unless the clock gate was already closed a cycle earlier;
- the frequency code never rises while the clock runs;
- the gate is open whenever the block is idle, and it reopens only with a completion pulse;
- the error pulses line up with busy, done and unchanged codes.

Some behaviours depend on a full transaction, so only the directed scenarios can show them:
- the direction-dependent ordering of the two changes;
- the exact one-cycle lead of the gate;
- the table values;
- the timeout cycle count and the restored point after an aborted move.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_UP_GATE  = 3'd1,
    S_UP_WAIT  = 3'd2,
    S_DN_GATE  = 3'd3,
    S_DN_VSET  = 3'd4,
    S_DN_WAIT  = 3'd5,
    S_RST_WAIT = 3'd6,
    S_FINISH   = 3'd7
  } seq_state_e;

  localparam int V_LOW_CODE  = 60;
  localparam int V_HIGH_CODE = 105;
  localparam int F_LOW_CODE  = 300;
  localparam int F_HIGH_CODE = 3000;

  // voltage code of point idx in an n-entry table, spread linearly
  function automatic int point_vcode(input int idx, input int n);
    return V_LOW_CODE + (idx * (V_HIGH_CODE - V_LOW_CODE)) / (n - 1);
  endfunction

  // frequency code of point idx in an n-entry table, spread linearly
  function automatic int point_fcode(input int idx, input int n);
    return F_LOW_CODE + (idx * (F_HIGH_CODE - F_LOW_CODE)) / (n - 1);
  endfunction

endpackage

// File: rtl/dvfs_op_table.sv
module dvfs_op_table #(
  parameter int NUM_POINTS = 8,
  parameter int IDX_W      = 4,
  parameter int VCODE_W    = 8,
  parameter int FCODE_W    = 12
) (
  input  logic [IDX_W-1:0]   tgt_idx,
  input  logic [IDX_W-1:0]   prv_idx,
  output logic [VCODE_W-1:0] tgt_v,
  output logic [FCODE_W-1:0] tgt_f,
  output logic [VCODE_W-1:0] prv_v,
  output logic [FCODE_W-1:0] prv_f
);
  import dvfs_seq_pkg::*;

  logic [VCODE_W-1:0] v_tab [NUM_POINTS];
  logic [FCODE_W-1:0] f_tab [NUM_POINTS];

  // each entry is a constant computed from its position
  for (genvar g = 0; g < NUM_POINTS; g++) begin : g_entry
    assign v_tab[g] = VCODE_W'(point_vcode(g, NUM_POINTS));
    assign f_tab[g] = FCODE_W'(point_fcode(g, NUM_POINTS));
  end

  // read ports fall back to entry 0 for an index beyond the table
  always_comb begin
    tgt_v = v_tab[0];
    tgt_f = f_tab[0];
    prv_v = v_tab[0];
    prv_f = f_tab[0];
    for (int i = 0; i < NUM_POINTS; i++) begin
      if (32'(tgt_idx) == i) begin
        tgt_v = v_tab[i];
        tgt_f = f_tab[i];
      end
      if (32'(prv_idx) == i) begin
        prv_v = v_tab[i];
        prv_f = f_tab[i];
      end
    end
  end

endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clear) begin
      cnt_n = '0;
    end else if (run && !expired) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  // a zero budget behaves as one cycle
  assign expired = ({1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1}) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/dvfs_seq_fsm.sv
module dvfs_seq_fsm #(
  parameter int NUM_POINTS = 8,
  parameter int IDX_W      = 4,
  parameter int VCODE_W    = 8,
  parameter int FCODE_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_index,
  input  logic               vreg_settled,
  input  logic               tmo_expired,
  input  logic [VCODE_W-1:0] look_v,
  input  logic [FCODE_W-1:0] look_f,
  input  logic [VCODE_W-1:0] prev_v,
  input  logic [FCODE_W-1:0] prev_f,
  output logic [IDX_W-1:0]   look_idx,
  output logic [IDX_W-1:0]   cur_idx,
  output logic               tmr_clear,
  output logic               tmr_run,
  output logic [VCODE_W-1:0] vreg_code,
  output logic [FCODE_W-1:0] freq_code,
  output logic               clk_en,
  output logic               busy,
  output logic               done,
  output logic               err_range,
  output logic               err_overrun,
  output logic               err_timeout
);
  import dvfs_seq_pkg::*;

  localparam logic [VCODE_W-1:0] RST_V = VCODE_W'(point_vcode(0, NUM_POINTS));
  localparam logic [FCODE_W-1:0] RST_F = FCODE_W'(point_fcode(0, NUM_POINTS));

  seq_state_e         state_q, state_n;
  logic [IDX_W-1:0]   cur_q, cur_n;
  logic [IDX_W-1:0]   tgt_q, tgt_n;
  logic [VCODE_W-1:0] vreg_q, vreg_n;
  logic [FCODE_W-1:0] freq_q, freq_n;
  logic               clk_en_q, clk_en_n;
  logic               done_q, done_n;
  logic               erng_q, erng_n;
  logic               eovr_q, eovr_n;
  logic               etmo_q, etmo_n;
  logic               commit_q, commit_n;
  logic               tmo_q, tmo_n;
  logic               req_bad;
  logic               idle;

  assign idle     = (state_q == S_IDLE);
  assign req_bad  = (32'(req_index) >= NUM_POINTS);
  // while idle the lookup follows the incoming request
  assign look_idx = idle ? req_index : tgt_q;

  always_comb begin
    state_n   = state_q;
    cur_n     = cur_q;
    tgt_n     = tgt_q;
    vreg_n    = vreg_q;
    freq_n    = freq_q;
    clk_en_n  = clk_en_q;
    commit_n  = commit_q;
    tmo_n     = tmo_q;
    done_n    = 1'b0;
    erng_n    = 1'b0;
    etmo_n    = 1'b0;
    eovr_n    = req_valid && !idle;
    tmr_clear = 1'b1;
    tmr_run   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (req_bad) begin
            erng_n = 1'b1;
          end else if (req_index == cur_q) begin
            done_n = 1'b1;
          end else begin
            tgt_n    = req_index;
            commit_n = 1'b0;
            tmo_n    = 1'b0;
            if (req_index > cur_q) begin
              clk_en_n = 1'b0;
              state_n  = S_UP_GATE;
            end else begin
              freq_n  = look_f;
              state_n = S_DN_GATE;
            end
          end
        end
      end
      S_UP_GATE: begin
        vreg_n  = look_v;
        state_n = S_UP_WAIT;
      end
      S_DN_GATE: begin
        clk_en_n = 1'b0;
        state_n  = S_DN_VSET;
      end
      S_DN_VSET: begin
        vreg_n  = look_v;
        state_n = S_DN_WAIT;
      end
      S_UP_WAIT, S_DN_WAIT: begin
        tmr_clear = 1'b0;
        tmr_run   = 1'b1;
        if (vreg_settled) begin
          commit_n = 1'b1;
          state_n  = S_FINISH;
          if (state_q == S_UP_WAIT) begin
            freq_n = look_f;
          end
        end else if (tmo_expired) begin
          vreg_n    = prev_v;
          tmo_n     = 1'b1;
          tmr_clear = 1'b1;
          state_n   = S_RST_WAIT;
        end
      end
      S_RST_WAIT: begin
        tmr_clear = 1'b0;
        tmr_run   = 1'b1;
        if (vreg_settled || tmo_expired) begin
          freq_n  = prev_f;
          state_n = S_FINISH;
        end
      end
      S_FINISH: begin
        clk_en_n = 1'b1;
        done_n   = 1'b1;
        etmo_n   = tmo_q;
        if (commit_q) begin
          cur_n = tgt_q;
        end
        state_n = S_IDLE;
      end
      default: begin
        state_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      tgt_q    <= '0;
      vreg_q   <= RST_V;
      freq_q   <= RST_F;
      clk_en_q <= 1'b1;
      done_q   <= 1'b0;
      erng_q   <= 1'b0;
      eovr_q   <= 1'b0;
      etmo_q   <= 1'b0;
      commit_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      cur_q    <= cur_n;
      tgt_q    <= tgt_n;
      vreg_q   <= vreg_n;
      freq_q   <= freq_n;
      clk_en_q <= clk_en_n;
      done_q   <= done_n;
      erng_q   <= erng_n;
      eovr_q   <= eovr_n;
      etmo_q   <= etmo_n;
      commit_q <= commit_n;
      tmo_q    <= tmo_n;
    end
  end

  assign cur_idx     = cur_q;
  assign vreg_code   = vreg_q;
  assign freq_code   = freq_q;
  assign clk_en      = clk_en_q;
  assign busy        = !idle;
  assign done        = done_q;
  assign err_range   = erng_q;
  assign err_overrun = eovr_q;
  assign err_timeout = etmo_q;

endmodule

// File: rtl/dvfs_seq_top.sv
module dvfs_seq_top #(
  parameter int NUM_POINTS = 8,
  parameter int IDX_W      = 4,
  parameter int VCODE_W    = 8,
  parameter int FCODE_W    = 12,
  parameter int TMO_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [TMO_W-1:0]   timeout_limit,
  input  logic               vreg_settled,
  output logic [VCODE_W-1:0] vreg_code,
  output logic [FCODE_W-1:0] freq_code,
  output logic               clk_en,
  output logic               busy,
  output logic               done,
  output logic               err_range,
  output logic               err_overrun,
  output logic               err_timeout,
  output logic [IDX_W-1:0]   cur_index
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [IDX_W-1:0]   look_idx;
  logic [VCODE_W-1:0] look_v;
  logic [FCODE_W-1:0] look_f;
  logic [VCODE_W-1:0] prev_v;
  logic [FCODE_W-1:0] prev_f;
  logic               tmr_clear;
  logic               tmr_run;
  logic               tmo_expired;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dvfs_op_table #(
    .NUM_POINTS (NUM_POINTS),
    .IDX_W      (IDX_W),
    .VCODE_W    (VCODE_W),
    .FCODE_W    (FCODE_W)
  ) table_i (
    .tgt_idx (look_idx),
    .prv_idx (cur_index),
    .tgt_v   (look_v),
    .tgt_f   (look_f),
    .prv_v   (prev_v),
    .prv_f   (prev_f)
  );

  dvfs_settle_timer #(
    .TMO_W (TMO_W)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .limit   (timeout_limit),
    .expired (tmo_expired)
  );

  dvfs_seq_fsm #(
    .NUM_POINTS (NUM_POINTS),
    .IDX_W      (IDX_W),
    .VCODE_W    (VCODE_W),
    .FCODE_W    (FCODE_W)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .req_index    (req_index),
    .vreg_settled (vreg_settled),
    .tmo_expired  (tmo_expired),
    .look_v       (look_v),
    .look_f       (look_f),
    .prev_v       (prev_v),
    .prev_f       (prev_f),
    .look_idx     (look_idx),
    .cur_idx      (cur_index),
    .tmr_clear    (tmr_clear),
    .tmr_run      (tmr_run),
    .vreg_code    (vreg_code),
    .freq_code    (freq_code),
    .clk_en       (clk_en),
    .busy         (busy),
    .done         (done),
    .err_range    (err_range),
    .err_overrun  (err_overrun),
    .err_timeout  (err_timeout)
  );

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int VCODE_W = 8,
  parameter int FCODE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VCODE_W-1:0] vreg_code,
  input logic [FCODE_W-1:0] freq_code,
  input logic               clk_en,
  input logic               busy,
  input logic               done,
  input logic               err_range,
  input logic               err_overrun,
  input logic               err_timeout
);

  // R5: the rail target only moves with the gate already closed a cycle earlier
  assert_gate_leads_vreg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_code != $past(vreg_code)) |-> (!clk_en && !$past(clk_en)));

  // R3: raising the frequency never happens with the clock running
  assert_no_fast_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code > $past(freq_code)) |-> !clk_en);

  // R5: idle means the clock is open
  assert_idle_clock_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> clk_en);

  // R6: the gate reopens only together with completion
  assert_reopen_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> done);

  // R6: completion is reported with busy already dropped
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: overrun only follows a busy cycle
  assert_overrun_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> $past(busy));

  // R11: timeout error is reported with the completion pulse
  assert_timeout_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> done);

  // R8: a rejected request disturbs neither code
  assert_range_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |-> ($stable(vreg_code) && $stable(freq_code) && !done));

endmodule

bind dvfs_seq_top dvfs_seq_chk #(
  .VCODE_W (VCODE_W),
  .FCODE_W (FCODE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .vreg_code   (vreg_code),
  .freq_code   (freq_code),
  .clk_en      (clk_en),
  .busy        (busy),
  .done        (done),
  .err_range   (err_range),
  .err_overrun (err_overrun),
  .err_timeout (err_timeout)
);

// File: tb/dvfs_seq_tb.sv
`timescale 1ns/1ps
module dvfs_seq_top_tb_top;
  localparam int N      = 8;
  localparam int IDX_W  = 4;
  localparam int VW     = 8;
  localparam int FW     = 12;
  localparam int TW     = 16;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [IDX_W-1:0] req_index;
  logic [TW-1:0]    timeout_limit;
  logic             vreg_settled;
  logic [VW-1:0]    vreg_code;
  logic [FW-1:0]    freq_code;
  logic             clk_en;
  logic             busy;
  logic             done;
  logic             err_range;
  logic             err_overrun;
  logic             err_timeout;
  logic [IDX_W-1:0] cur_index;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dvfs_seq_top #(.NUM_POINTS(N), .IDX_W(IDX_W), .VCODE_W(VW), .FCODE_W(FW), .TMO_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .timeout_limit(timeout_limit), .vreg_settled(vreg_settled),
    .vreg_code(vreg_code), .freq_code(freq_code), .clk_en(clk_en), .busy(busy),
    .done(done), .err_range(err_range), .err_overrun(err_overrun),
    .err_timeout(err_timeout), .cur_index(cur_index));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected table, from the requirement formula
  function automatic int exp_v(input int i);
    return 60 + (i * 45) / (N - 1);
  endfunction
  function automatic int exp_f(input int i);
    return 300 + (i * 2700) / (N - 1);
  endfunction

  // regulator model and observation, all at the falling edge
  int  reg_delay = 4;
  bit  reg_stuck = 0;
  int  reg_cnt = 0;
  logic [VW-1:0] reg_last;
  int  cyc = 0;
  logic [VW-1:0] pv;
  logic [FW-1:0] pf;
  logic          pe;
  int  v_first, v_last, f_first, gate_fall, gate_rise, v_changes, f_changes;
  bit  seen_done, seen_busy, seen_rng, seen_ovr, seen_tmo, tmo_with_done;

  task automatic clear_obs();
    v_first = -1; v_last = -1; f_first = -1; gate_fall = -1; gate_rise = -1;
    v_changes = 0; f_changes = 0;
    seen_done = 0; seen_busy = 0; seen_rng = 0; seen_ovr = 0; seen_tmo = 0;
    tmo_with_done = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      vreg_settled = 1'b1;
      reg_last = vreg_code;
    end else begin
      if (vreg_code !== reg_last) begin
        reg_last = vreg_code;
        vreg_settled = 1'b0;
        reg_cnt = reg_delay;
      end else if (!reg_stuck) begin
        if (reg_cnt > 0) reg_cnt--;
        else vreg_settled = 1'b1;
      end
      if (vreg_code !== pv) begin
        if (v_first < 0) v_first = cyc;
        v_last = cyc;
        v_changes++;
      end
      if (freq_code !== pf) begin
        if (f_first < 0) f_first = cyc;
        f_changes++;
      end
      if (pe === 1'b1 && clk_en === 1'b0) gate_fall = cyc;
      if (pe === 1'b0 && clk_en === 1'b1) gate_rise = cyc;
      if (done) seen_done = 1;
      if (busy) seen_busy = 1;
      if (err_range) seen_rng = 1;
      if (err_overrun) seen_ovr = 1;
      if (err_timeout) seen_tmo = 1;
      if (err_timeout && done) tmo_with_done = 1;
    end
    pv = vreg_code;
    pf = freq_code;
    pe = clk_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send_req(input int idx);
    @(negedge clk);
    req_valid = 1'b1;
    req_index = IDX_W'(idx);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!busy) begin
        repeat (2) @(negedge clk);
        return;
      end
    end
    chk(0, "wait for idle", 1, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_index = '0;
    timeout_limit = TW'(50);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cur_index == 0, "R1 index", int'(cur_index), 0);
    chk(vreg_code == VW'(exp_v(0)) && vreg_code == 60, "R1 vcode", int'(vreg_code), 60);
    chk(freq_code == FW'(exp_f(0)) && freq_code == 300, "R1 fcode", int'(freq_code), 300);
    chk(clk_en && !busy && !done && !err_range && !err_overrun && !err_timeout,
        "R1 flags", int'({clk_en, busy, done, err_range, err_overrun, err_timeout}), 32);
  endtask

  task automatic t_step_up(input int to);
    int from = int'(cur_index);
    clear_obs();
    send_req(to);
    wait_idle();
    chk(vreg_code == VW'(exp_v(to)), "R2 vcode after up", int'(vreg_code), exp_v(to));
    chk(freq_code == FW'(exp_f(to)), "R2 fcode after up", int'(freq_code), exp_f(to));
    chk(v_first > 0 && f_first > v_first + reg_delay, "R3 voltage settles before clock",
        f_first, v_first + reg_delay + 1);
    chk(v_first - gate_fall == 1, "R5 gate lead", v_first - gate_fall, 1);
    chk(gate_rise == f_first + 1, "R5 gate reopen", gate_rise, f_first + 1);
    chk(seen_done && seen_busy && cur_index == IDX_W'(to), "R6 up completion",
        int'(cur_index), to);
    if (from == 0) chk(1, "R6", 0, 0);
  endtask

  task automatic t_step_down(input int to);
    clear_obs();
    send_req(to);
    wait_idle();
    chk(vreg_code == VW'(exp_v(to)) && freq_code == FW'(exp_f(to)), "R2 codes after down",
        int'(freq_code), exp_f(to));
    chk(f_first > 0 && v_first > f_first, "R4 clock slows first", v_first, f_first + 1);
    chk(v_first - gate_fall == 1, "R5 gate lead down", v_first - gate_fall, 1);
    chk(seen_done && cur_index == IDX_W'(to), "R6 down completion", int'(cur_index), to);
  endtask

  task automatic t_same();
    int i0 = int'(cur_index);
    clear_obs();
    send_req(i0);
    repeat (3) @(negedge clk);
    chk(seen_done && !seen_busy && v_changes == 0 && f_changes == 0 && gate_fall < 0,
        "R7 same index", v_changes + f_changes, 0);
  endtask

  task automatic t_range(input int idx);
    int i0 = int'(cur_index);
    clear_obs();
    send_req(idx);
    repeat (3) @(negedge clk);
    chk(seen_rng && !seen_done && v_changes == 0 && f_changes == 0 && cur_index == IDX_W'(i0),
        "R8 out of range", int'(seen_rng), 1);
  endtask

  task automatic t_overrun(input int to, input int late);
    clear_obs();
    reg_delay = 20;
    send_req(to);
    repeat (3) @(negedge clk);
    send_req(late);
    wait_idle();
    reg_delay = 4;
    chk(seen_ovr, "R9 overrun flagged", int'(seen_ovr), 1);
    chk(cur_index == IDX_W'(to) && vreg_code == VW'(exp_v(to)), "R9 late request ignored",
        int'(cur_index), to);
  endtask

  task automatic t_timeout(input int to, input int lim);
    int i0 = int'(cur_index);
    clear_obs();
    timeout_limit = TW'(lim);
    reg_stuck = 1;
    send_req(to);
    wait_idle();
    reg_stuck = 0;
    repeat (reg_delay + 3) @(negedge clk);
    chk(v_last - v_first == lim, "R10 timeout cycle count", v_last - v_first, lim);
    chk(vreg_code == VW'(exp_v(i0)), "R10 voltage restored", int'(vreg_code), exp_v(i0));
    chk(freq_code == FW'(exp_f(i0)), "R11 frequency at previous point",
        int'(freq_code), exp_f(i0));
    chk(tmo_with_done && cur_index == IDX_W'(i0), "R11 timeout completion",
        int'(cur_index), i0);
    timeout_limit = TW'(50);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_obs();
    t_reset();
    t_step_up(3);
    t_step_up(7);
    t_step_down(2);
    t_step_down(0);
    t_same();
    t_step_up(5);
    t_same();
    t_range(N);
    t_range(15);
    t_overrun(6, 1);
    t_timeout(7, 10);
    t_timeout(2, 6);
    t_step_down(1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule